// File: doc/BRIEF.md
# Stretched pulse clock-domain synchronizer

This block moves single-bit event pulses from one clock domain into another clock domain that has no fixed phase or frequency relation to it. An event on the source side may be only one source cycle wide. The destination clock could miss a pulse that short. So the block first holds the event as a level in the source domain for a set number of source cycles. It then drives low for the same number of cycles, so that two events cannot merge. The widened level passes through a chain of destination-domain flip-flops. A rising-edge detector at the end of the chain turns each widened level into exactly one destination-cycle pulse.

While the source side is holding or guarding an event, it raises a busy flag. An event that arrives during that time is discarded, and a sticky overflow flag records the loss until the next source reset. The integrator chooses the stretch length so that it covers at least three destination periods. That is two periods for the chain to sample the level and one period of margin. The destination chain has two stages by default, and the stage count can be changed.

Top module: `pulse_xing`

## Requirements
- R1: While reset and right after reset, `src_busy`, `src_overflow` and `dst_pulse` are all 0. Every flop clears on the asynchronous active-low reset of its own domain.
- R2: A `src_pulse` that is high for a single source cycle while `src_busy` is 0 is accepted. `src_busy` reads 1 from the next source clock edge on.
- R3: After an accepted event, the widened level stays high for `STRETCH` source cycles and then stays low for `STRETCH` source cycles. `src_busy` is 1 for exactly 2*`STRETCH` source cycles.
- R4: Each accepted event produces exactly one `dst_pulse`, and that pulse is exactly one destination cycle wide.
- R5: `dst_pulse` stays 0 when no event has been accepted.
- R6: A `src_pulse` that arrives while `src_busy` is 1 is dropped and gives no `dst_pulse`. It sets `src_overflow` to 1 at the next source edge.
- R7: Once set, `src_overflow` stays 1 until the source reset is asserted. The reset clears it to 0.
- R8: A `src_pulse` in the first source cycle in which `src_busy` has returned to 0 is accepted.
- R9: If `STRETCH` source periods cover at least three destination periods, the number of `dst_pulse` events equals the number of accepted events. This holds whether the source clock is faster or slower than the destination clock.
- R10: The destination chain length is the parameter `STAGES`, with a default of 2. Each stage is a separate flop in series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_pulse | input | 1 | Event input, at least one source cycle wide |
| src_busy | output | 1 | High while an event is being held or guarded |
| src_overflow | output | 1 | Sticky flag: an event arrived while busy |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_pulse | output | 1 | One destination-cycle pulse per accepted event |

## Verification
Single isolated events show that one source cycle of input is enough and that the busy window has the exact length. Idle stretches show that no output appears without an event. An event injected in the middle of a busy window separates dropping from double counting, because the output count must stay the same while the overflow flag rises. An event in the first idle cycle separates a correct end of the window from an off-by-one error. Bursts of events are run once with the destination slower than the source and once with it faster. The bursts check that input and output counts match and that no output pulse is wider than one cycle in either ratio.

// File: rtl/pulse_xing_pkg.sv
package pulse_xing_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_GAP  = 2'd2
  } stretch_state_e;
endpackage

// File: rtl/pulse_xing_stretch.sv
module pulse_xing_stretch
  import pulse_xing_pkg::*;
#(
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic level,
  output logic busy,
  output logic overflow
);
  localparam int CW = (STRETCH > 2) ? $clog2(STRETCH) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

  stretch_state_e state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           ovf_q, ovf_d;
  logic           accept;

  assign busy   = (state_q != ST_IDLE);
  assign level  = (state_q == ST_HOLD);
  assign accept = evt && !busy;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q | (evt & busy);
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_HOLD;
          cnt_d   = LAST;
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          state_d = ST_GAP;
          cnt_d   = LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
    end
  end

  assign overflow = ovf_q;

  // R2: an idle-time event raises busy and the level on the next edge
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !busy) |=> (busy && level));

  // R3: the level always falls into a guard gap, never straight to idle
  assert_gap_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level) |-> busy);

  // R6: an event during busy sets overflow
  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && busy) |=> overflow);

  // R7: overflow is sticky
  assert_no_overflow_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/pulse_xing_sync.sv
module pulse_xing_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

  // R10: output is the value the first stage held STAGES-1 cycles earlier (two-stage case)
  if (STAGES == 2) begin : g_chk2
    assert_chain_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(stage_q[0], 1));
  end
endmodule

// File: rtl/pulse_xing_edge.sv
module pulse_xing_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q, prev_d;

  assign prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;

  // R4: an output pulse is never longer than one destination cycle
  assert_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pulse_xing.sv
module pulse_xing #(
  parameter int STRETCH = 8,
  parameter int STAGES  = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  output logic src_busy,
  output logic src_overflow,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic src_level;
  logic dst_level;

  pulse_xing_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .evt      (src_pulse),
    .level    (src_level),
    .busy     (src_busy),
    .overflow (src_overflow)
  );

  pulse_xing_sync #(.STAGES(STAGES)) u_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (src_level),
    .q     (dst_level)
  );

  pulse_xing_edge u_edge (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .lvl   (dst_level),
    .rise  (dst_pulse)
  );

  // R5: an output pulse needs the synchronized level to be high
  assert_pulse_needs_level_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |-> dst_level);
endmodule

// File: tb/pulse_xing_test.sv
`timescale 1ns/1ps
module pulse_xing_test;
  localparam int STRETCH = 8;
  localparam int STAGES  = 2;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic src_pulse = 1'b0;
  logic src_busy, src_overflow, dst_pulse;
  real  dst_half = 23.5;

  int checks = 0;
  int errors = 0;
  int dst_count = 0;
  int wide_count = 0;
  bit prev_p = 1'b0;
  bit finished = 1'b0;

  always #10 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  pulse_xing #(.STRETCH(STRETCH), .STAGES(STAGES)) uut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_pulse(src_pulse),
    .src_busy(src_busy), .src_overflow(src_overflow),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_pulse(dst_pulse)
  );

  always @(negedge dst_clk) begin
    if (dst_pulse) dst_count++;
    if (dst_pulse && prev_p) wide_count++;
    prev_p = dst_pulse;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge src_clk);
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    src_pulse = 1'b0;
    repeat (3) @(negedge src_clk);
    src_rst_n = 1'b1;
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    repeat (2) @(negedge src_clk);
  endtask

  task automatic send_pulse();
    @(negedge src_clk);
    src_pulse = 1'b1;
    @(negedge src_clk);
    src_pulse = 1'b0;
  endtask

  task automatic drain();
    while (src_busy) @(negedge src_clk);
    #500;
  endtask

  task automatic t_reset_state();
    chk(src_busy == 1'b0, "R1 busy", int'(src_busy), 0);
    chk(src_overflow == 1'b0, "R1 overflow", int'(src_overflow), 0);
    chk(dst_pulse == 1'b0, "R1 dst_pulse", int'(dst_pulse), 0);
  endtask

  task automatic t_single();
    int base = dst_count;
    int n = 0;
    send_pulse();
    chk(src_busy == 1'b1, "R2 busy after accept", int'(src_busy), 1);
    while (src_busy) begin
      n++;
      @(negedge src_clk);
    end
    chk(n == 2 * STRETCH, "R3 busy length", n, 2 * STRETCH);
    drain();
    chk(dst_count - base == 1, "R4 one output per event", dst_count - base, 1);
    chk(wide_count == 0, "R4 output width", wide_count, 0);
  endtask

  task automatic t_idle();
    int base = dst_count;
    #2000;
    chk(dst_count == base, "R5 no output when idle", dst_count - base, 0);
  endtask

  task automatic t_drop();
    int base = dst_count;
    chk(src_overflow == 1'b0, "R6 overflow before drop", int'(src_overflow), 0);
    send_pulse();
    repeat (2) @(negedge src_clk);
    send_pulse();
    chk(src_overflow == 1'b1, "R6 overflow set", int'(src_overflow), 1);
    drain();
    chk(dst_count - base == 1, "R6 dropped event gives no output", dst_count - base, 1);
    #1000;
    chk(src_overflow == 1'b1, "R7 overflow sticky", int'(src_overflow), 1);
    do_reset();
    chk(src_overflow == 1'b0, "R7 overflow cleared by reset", int'(src_overflow), 0);
  endtask

  task automatic t_back_to_back();
    int base = dst_count;
    send_pulse();
    while (src_busy) @(negedge src_clk);
    src_pulse = 1'b1;
    @(negedge src_clk);
    src_pulse = 1'b0;
    chk(src_busy == 1'b1, "R8 accept on first idle cycle", int'(src_busy), 1);
    chk(src_overflow == 1'b0, "R8 no overflow", int'(src_overflow), 0);
    drain();
    chk(dst_count - base == 2, "R8 two outputs", dst_count - base, 2);
  endtask

  task automatic t_burst(input string tag, input int nev);
    int base = dst_count;
    int wbase = wide_count;
    for (int i = 0; i < nev; i++) begin
      send_pulse();
      repeat (i % 3) @(negedge src_clk);
      while (src_busy) @(negedge src_clk);
    end
    drain();
    chk(dst_count - base == nev, {"R9 count ", tag}, dst_count - base, nev);
    chk(wide_count == wbase, {"R4 width ", tag}, wide_count - wbase, 0);
    chk(src_overflow == 1'b0, {"R9 no overflow ", tag}, int'(src_overflow), 0);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #5;
    chk(src_busy == 1'b0 && dst_pulse == 1'b0, "R1 during reset", int'(src_busy), 0);
    do_reset();
    t_reset_state();
    // destination slower than source (47 ns vs 20 ns)
    t_single();
    t_idle();
    t_drop();
    t_back_to_back();
    t_burst("fast-to-slow", 10);
    // destination faster than source (7 ns vs 20 ns)
    dst_half = 3.5;
    do_reset();
    t_reset_state();
    t_single();
    t_back_to_back();
    t_burst("slow-to-fast", 12);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule